// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block keeps coherence state for a small direct-mapped processor cache on a shared snooping bus. Each line is Invalid, Shared (read-only copy) or Exclusive (the only copy, possibly dirty). The block compares tags itself to classify a CPU request as a hit or a miss. On a miss or a write to a Shared line it issues a bus command. When an Exclusive line is displaced it asks for that line to be written back.

Snooped bus traffic from other caches is looked up in a second copy of the tags and states. Snoop lookups therefore never wait for the CPU port. A snoop that finds this cache's Exclusive copy forces a write-back of that line. A snooped write miss removes this cache's copy. Every state change is written into both copies in the same clock edge.

Bus commands leave on a valid/ready handshake. The CPU request must stay asserted until `cpuDone` pulses. Addresses are `{tag, index}`, with the index in the low `IDX_W` bits.

Top module: `snoopCohCtrl`

## Requirements
- R1: After reset every line is Invalid. A CPU read of any address is a miss that issues a read-miss command with no write-back, and a snoop gets no write-back.
- R2: On an Invalid line, a CPU read issues a read miss (`busCmd`=0) and leaves the line Shared. A CPU write issues a write miss (`busCmd`=1) and leaves it Exclusive. Neither requests a write-back.
- R3: On a Shared line, a read hit completes in the same cycle with no bus command. A read miss issues a read miss and the line stays Shared with the new tag. A write hit or a write miss issues a write miss and the line becomes Exclusive. None of these requests a write-back.
- R4: On an Exclusive line, read hits and write hits complete in the same cycle. They issue no bus command and do not change the state.
- R5: On an Exclusive line, a CPU miss asserts `cpuWbValid` with `cpuWbAddr` set to the old tag and the index, alongside the command. A read miss leaves the line Shared and a write miss leaves it Exclusive, both with the new tag.
- R6: A snooped write miss that hits a Shared line makes it Invalid without a write-back. A snooped read miss that hits a Shared line changes nothing.
- R7: A snoop that hits an Exclusive line asserts `snpWbValid` in the same cycle. A snooped read miss (`snpWrite`=0) then leaves the line Shared, and a snooped write miss (`snpWrite`=1) leaves it Invalid.
- R8: A snoop whose tag differs from the stored tag, or that targets an Invalid line, asserts no write-back and changes no state.
- R9: A bus command appears one cycle after the request is taken. It holds `busCmd` and `busCmdAddr` steady while `busCmdReady` is low. `cpuDone` pulses in the cycle the command is accepted.
- R10: When a snoop and a CPU request hit the same index in the same cycle, the snoop is applied first and the CPU request completes no earlier than the next cycle. It is then evaluated against the state the snoop left behind.
- R11: A snoop that writes back the victim line while a command is waiting withdraws the pending victim write-back (`cpuWbValid` low from that cycle on).
- R12: A snoop and a CPU request to different indexes in the same cycle are both served in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | CPU request present; held until `cpuDone` |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | TAG_W+IDX_W | CPU address `{tag, index}` |
| cpuDone | output | 1 | Request completes this cycle |
| busCmdValid | output | 1 | Bus command offered |
| busCmd | output | 1 | 0 = read miss, 1 = write miss |
| busCmdAddr | output | TAG_W+IDX_W | Address carried by the command |
| busCmdReady | input | 1 | Bus takes the command |
| cpuWbValid | output | 1 | Victim line must be written back |
| cpuWbAddr | output | TAG_W+IDX_W | Victim address `{old tag, index}` |
| snpValid | input | 1 | Snooped bus request present |
| snpWrite | input | 1 | 1 = snooped write miss, 0 = snooped read miss |
| snpAddr | input | TAG_W+IDX_W | Snooped address |
| snpWbValid | output | 1 | This cache holds the snooped line Exclusive and must write it back |

## Verification
The bench goes after the cases where the CPU side and the snoop side interact. A same-index snoop and CPU read in one cycle must turn a would-be hit into a read miss. A design that let the CPU win would report a hit on an invalidated line. A snoop that flushes the victim during a stalled command must withdraw the victim write-back, or memory receives stale data twice. Unmatched snoops must leave the line untouched, since a design that compared only the index would drop or demote lines that belong to others. Each state change is read back later through hit or miss behaviour, so a design that updated one tag copy but not the other shows up as a wrong hit or a missing snoop write-back.

// File: rtl/cohPkg.sv
package cohPkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2
  } lineState_t;

  // strobes from control to the tag stores
  typedef struct packed {
    logic       fill;
    lineState_t fillState;
  } ctlStrb_t;
endpackage

// File: rtl/cohDatapath.sv
module cohDatapath
  import cohPkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDX_W+TAG_W-1:0] cpuAddr,
  input  logic [IDX_W+TAG_W-1:0] snpAddr,
  input  logic                   snpValid,
  input  logic                   snpWrite,
  input  ctlStrb_t               strb,
  output logic                   cpuHit,
  output lineState_t             cpuState,
  output logic                   victimDirty,
  output logic [IDX_W+TAG_W-1:0] victimAddr,
  output logic                   idxClash,
  output logic                   snpWbValid
);
  localparam int ADDR_W = IDX_W + TAG_W;
  localparam int LINES  = 1 << IDX_W;

  // CPU-side copy and snoop-side copy of tags and states
  logic [TAG_W-1:0] cTag [LINES];
  lineState_t       cSt  [LINES];
  logic [TAG_W-1:0] sTag [LINES];
  lineState_t       sSt  [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTg, snpTg;
  logic             sHit, snpUpd, snpKillsVictim;
  lineState_t       sCur, snpNext;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTg  = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTg  = snpAddr[ADDR_W-1:IDX_W];

  // snoop-side lookup
  always_comb begin
    sCur       = sSt[snpIdx];
    sHit       = (sCur != ST_I) && (sTag[snpIdx] == snpTg);
    snpWbValid = snpValid && sHit && (sCur == ST_E);
    snpUpd     = snpValid && sHit;
    if (snpWrite)          snpNext = ST_I;
    else if (sCur == ST_E) snpNext = ST_S;
    else                   snpNext = sCur;
  end

  // CPU-side lookup
  always_comb begin
    cpuState       = cSt[cpuIdx];
    cpuHit         = (cpuState != ST_I) && (cTag[cpuIdx] == cpuTg);
    idxClash       = snpValid && (snpIdx == cpuIdx);
    snpKillsVictim = idxClash && snpWbValid;
    victimDirty    = (cpuState == ST_E) && (cTag[cpuIdx] != cpuTg) && !snpKillsVictim;
    victimAddr     = {cTag[cpuIdx], cpuIdx};
  end

  // both copies take every update on the same edge; a fill wins over a snoop
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rstN) begin
        cSt[i]  <= ST_I;
        sSt[i]  <= ST_I;
        cTag[i] <= '0;
        sTag[i] <= '0;
      end else if (strb.fill && (cpuIdx == IDX_W'(i))) begin
        cSt[i]  <= strb.fillState;
        sSt[i]  <= strb.fillState;
        cTag[i] <= cpuTg;
        sTag[i] <= cpuTg;
      end else if (snpUpd && (snpIdx == IDX_W'(i))) begin
        cSt[i] <= snpNext;
        sSt[i] <= snpNext;
      end
    end
  end
endmodule

// File: rtl/cohControl.sv
module cohControl
  import cohPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReqValid,
  input  logic       cpuReqWrite,
  input  logic       cpuHit,
  input  lineState_t cpuState,
  input  logic       victimDirty,
  input  logic       idxClash,
  input  logic       busCmdReady,
  output logic       busCmdValid,
  output logic       busCmd,
  output logic       cpuWbValid,
  output logic       cpuDone,
  output ctlStrb_t   strb
);
  typedef enum logic {PH_IDLE, PH_ISSUE} ctlPhase_t;
  ctlPhase_t phase, phaseNext;
  logic      silentHit;

  assign silentHit = cpuHit && (!cpuReqWrite || (cpuState == ST_E));

  always_comb begin
    phaseNext      = phase;
    busCmdValid    = 1'b0;
    busCmd         = cpuReqWrite;
    cpuWbValid     = 1'b0;
    cpuDone        = 1'b0;
    strb.fill      = 1'b0;
    strb.fillState = cpuReqWrite ? ST_E : ST_S;
    unique case (phase)
      PH_IDLE: begin
        // a snoop to the same index goes first; retry next cycle
        if (cpuReqValid && !idxClash) begin
          if (silentHit) cpuDone   = 1'b1;
          else           phaseNext = PH_ISSUE;
        end
      end
      PH_ISSUE: begin
        busCmdValid = 1'b1;
        cpuWbValid  = victimDirty;
        if (busCmdReady) begin
          cpuDone   = 1'b1;
          strb.fill = 1'b1;
          phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/snoopCohCtrl.sv
module snoopCohCtrl
  import cohPkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuReqValid,
  input  logic                   cpuReqWrite,
  input  logic [TAG_W+IDX_W-1:0] cpuReqAddr,
  output logic                   cpuDone,
  output logic                   busCmdValid,
  output logic                   busCmd,
  output logic [TAG_W+IDX_W-1:0] busCmdAddr,
  input  logic                   busCmdReady,
  output logic                   cpuWbValid,
  output logic [TAG_W+IDX_W-1:0] cpuWbAddr,
  input  logic                   snpValid,
  input  logic                   snpWrite,
  input  logic [TAG_W+IDX_W-1:0] snpAddr,
  output logic                   snpWbValid
);
  ctlStrb_t   strb;
  logic       cpuHit, victimDirty, idxClash;
  lineState_t cpuState;

  assign busCmdAddr = cpuReqAddr;

  cohDatapath #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuReqAddr), .snpAddr(snpAddr),
    .snpValid(snpValid), .snpWrite(snpWrite),
    .strb(strb),
    .cpuHit(cpuHit), .cpuState(cpuState),
    .victimDirty(victimDirty), .victimAddr(cpuWbAddr),
    .idxClash(idxClash), .snpWbValid(snpWbValid)
  );

  cohControl u_ctl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite),
    .cpuHit(cpuHit), .cpuState(cpuState),
    .victimDirty(victimDirty), .idxClash(idxClash),
    .busCmdReady(busCmdReady),
    .busCmdValid(busCmdValid), .busCmd(busCmd),
    .cpuWbValid(cpuWbValid), .cpuDone(cpuDone),
    .strb(strb)
  );
endmodule

// File: rtl/snoopCohCtrl_chk.sv
module snoopCohCtrl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReqValid,
  input logic          cpuReqWrite,
  input logic          cpuDone,
  input logic          busCmdValid,
  input logic          busCmd,
  input logic [AW-1:0] busCmdAddr,
  input logic          busCmdReady,
  input logic          cpuWbValid,
  input logic          snpValid,
  input logic          snpWbValid
);
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid && !busCmdReady |=> busCmdValid && $stable(busCmd) && $stable(busCmdAddr)); // R9
  AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid && busCmdReady |-> cpuDone); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !busCmdValid); // R9
  AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid |-> cpuReqValid && (busCmd == cpuReqWrite)); // R3
  AST_WB_WITH_CMD: assert property (@(posedge clk) disable iff (!rstN)
    cpuWbValid |-> busCmdValid); // R5
  AST_SNPWB_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    snpWbValid |-> snpValid); // R7
endmodule

bind snoopCohCtrl snoopCohCtrl_chk #(.AW(TAG_W+IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite),
  .cpuDone(cpuDone), .busCmdValid(busCmdValid), .busCmd(busCmd),
  .busCmdAddr(busCmdAddr), .busCmdReady(busCmdReady), .cpuWbValid(cpuWbValid),
  .snpValid(snpValid), .snpWbValid(snpWbValid)
);

// File: tb/snoopCohCtrl_bench.sv
module snoopCohCtrl_bench;
  localparam int IDX_W = 2;
  localparam int TAG_W = 4;
  localparam int AW    = IDX_W + TAG_W;
  localparam int LINES = 1 << IDX_W;
  localparam int ST_I = 0, ST_S = 1, ST_E = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [AW-1:0] cpuReqAddr = '0;
  logic cpuDone, busCmdValid, busCmd, cpuWbValid, snpWbValid;
  logic [AW-1:0] busCmdAddr, cpuWbAddr;
  logic busCmdReady = 1'b0;
  logic snpValid = 1'b0, snpWrite = 1'b0;
  logic [AW-1:0] snpAddr = '0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int mSt [LINES];
  logic [TAG_W-1:0] mTag [LINES];

  always #4 clk = ~clk;

  snoopCohCtrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoopCohCtrl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite), .cpuReqAddr(cpuReqAddr),
    .cpuDone(cpuDone), .busCmdValid(busCmdValid), .busCmd(busCmd),
    .busCmdAddr(busCmdAddr), .busCmdReady(busCmdReady),
    .cpuWbValid(cpuWbValid), .cpuWbAddr(cpuWbAddr),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr),
    .snpWbValid(snpWbValid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cpuOp(input bit wr, input logic [TAG_W-1:0] tg, input int ix,
                       input int dly, input string req);
    int  st = mSt[ix];
    logic [TAG_W-1:0] mt = mTag[ix];
    bit  hit = (st != ST_I) && (mt == tg);
    bit  silent = hit && (!wr || st == ST_E);
    bit  expWb = (st == ST_E) && (mt != tg);
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = wr; cpuReqAddr = {tg, IDX_W'(ix)};
    #1;
    chk(req, "cpuDone@take", int'(cpuDone), int'(silent));
    chk(req, "busCmdValid@take", int'(busCmdValid), 0);
    if (!silent) begin
      for (int d = 0; d <= dly; d++) begin
        @(negedge clk);
        busCmdReady = (d == dly);
        #1;
        chk(req, "busCmdValid", int'(busCmdValid), 1);
        chk(req, "busCmd", int'(busCmd), int'(wr));
        chk(req, "busCmdAddr", int'(busCmdAddr), int'({tg, IDX_W'(ix)}));
        chk(req, "cpuWbValid", int'(cpuWbValid), int'(expWb));
        if (expWb) chk(req, "cpuWbAddr", int'(cpuWbAddr), int'({mt, IDX_W'(ix)}));
        chk(req, "cpuDone", int'(cpuDone), int'(d == dly));
      end
      mSt[ix]  = wr ? ST_E : ST_S;
      mTag[ix] = tg;
    end
    @(negedge clk);
    cpuReqValid = 1'b0; busCmdReady = 1'b0;
  endtask

  task automatic snoop(input bit wr, input logic [TAG_W-1:0] tg, input int ix, input string req);
    int st = mSt[ix];
    bit hit = (st != ST_I) && (mTag[ix] == tg);
    @(negedge clk);
    snpValid = 1'b1; snpWrite = wr; snpAddr = {tg, IDX_W'(ix)};
    #1;
    chk(req, "snpWbValid", int'(snpWbValid), int'(hit && st == ST_E));
    if (hit) begin
      if (wr) mSt[ix] = ST_I;
      else if (st == ST_E) mSt[ix] = ST_S;
    end
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  task automatic gotoState(input int ix, input int st, input logic [TAG_W-1:0] tg);
    if (mSt[ix] == ST_S) snoop(1'b1, mTag[ix], ix, "R6");
    else if (mSt[ix] == ST_E) snoop(1'b1, mTag[ix], ix, "R7");
    if (st == ST_S) cpuOp(1'b0, tg, ix, 0, "R2");
    else if (st == ST_E) cpuOp(1'b1, tg, ix, 1, "R2");
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mSt[i] = ST_I; mTag[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "busCmdValid", int'(busCmdValid), 0);
    chk("R1", "cpuDone", int'(cpuDone), 0);
    for (int ix = 0; ix < LINES; ix++) begin
      snoop(1'b1, 4'h0, ix, "R1");
      cpuOp(1'b0, 4'h0, ix, 0, "R1");
    end
    // CPU sweep: every state, op, hit/miss, on every line
    for (int ix = 0; ix < LINES; ix++)
      for (int st = 0; st < 3; st++)
        for (int wr = 0; wr < 2; wr++)
          for (int h = 0; h < 2; h++) begin
            logic [TAG_W-1:0] tA = TAG_W'(ix + 1);
            logic [TAG_W-1:0] tg = (h != 0) ? tA : (tA ^ 4'h8);
            gotoState(ix, st, tA);
            cpuOp(wr[0], tg, ix, (ix + wr) % 3,
                  (st == ST_I) ? "R2" : (st == ST_S) ? "R3" : (h != 0) ? "R4" : "R5");
            cpuOp(1'b0, tg, ix, 0, "R3");  // read back the resulting state
          end
    // Snoop sweep
    for (int ix = 0; ix < LINES; ix++)
      for (int st = 0; st < 3; st++)
        for (int sw = 0; sw < 2; sw++)
          for (int m = 0; m < 2; m++) begin
            logic [TAG_W-1:0] tA = TAG_W'(ix + 5);
            string nm;
            nm = (m == 0 || st == ST_I) ? "R8" : (st == ST_S) ? "R6" : "R7";
            gotoState(ix, st, tA);
            snoop(sw[0], (m != 0) ? tA : (tA ^ 4'h4), ix, nm);
            cpuOp(1'b0, tA, ix, 0, nm);  // probe state left by the snoop
          end

    // R10: same-index snoop and CPU request in one cycle
    gotoState(0, ST_E, 4'h3);
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b0; cpuReqAddr = {4'h3, 2'd0};
    snpValid = 1'b1; snpWrite = 1'b1; snpAddr = {4'h3, 2'd0};
    #1;
    chk("R10", "snpWbValid", int'(snpWbValid), 1);
    chk("R10", "cpuDone", int'(cpuDone), 0);
    @(negedge clk); snpValid = 1'b0; #1;
    chk("R10", "cpuDone after snoop", int'(cpuDone), 0);
    chk("R10", "busCmdValid", int'(busCmdValid), 0);
    @(negedge clk); busCmdReady = 1'b1; #1;
    chk("R10", "busCmdValid", int'(busCmdValid), 1);
    chk("R10", "busCmd", int'(busCmd), 0);
    chk("R10", "cpuWbValid", int'(cpuWbValid), 0);
    chk("R10", "cpuDone", int'(cpuDone), 1);
    @(negedge clk); cpuReqValid = 1'b0; busCmdReady = 1'b0;
    mSt[0] = ST_S; mTag[0] = 4'h3;
    cpuOp(1'b0, 4'h3, 0, 0, "R10");

    // R11: snoop flushes the victim while the command waits
    gotoState(1, ST_E, 4'hA);
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b1; cpuReqAddr = {4'hB, 2'd1};
    #1; chk("R11", "cpuDone@take", int'(cpuDone), 0);
    @(negedge clk); #1;
    chk("R11", "busCmdValid", int'(busCmdValid), 1);
    chk("R11", "cpuWbValid before", int'(cpuWbValid), 1);
    @(negedge clk); snpValid = 1'b1; snpWrite = 1'b0; snpAddr = {4'hA, 2'd1}; #1;
    chk("R11", "snpWbValid", int'(snpWbValid), 1);
    chk("R11", "cpuWbValid same cycle", int'(cpuWbValid), 0);
    @(negedge clk); snpValid = 1'b0; #1;
    chk("R11", "cpuWbValid after", int'(cpuWbValid), 0);
    chk("R11", "busCmdValid held", int'(busCmdValid), 1);
    @(negedge clk); busCmdReady = 1'b1; #1;
    chk("R11", "cpuDone", int'(cpuDone), 1);
    @(negedge clk); cpuReqValid = 1'b0; busCmdReady = 1'b0;
    mSt[1] = ST_E; mTag[1] = 4'hB;
    cpuOp(1'b1, 4'hB, 1, 0, "R11");

    // R12: different indexes served together
    gotoState(2, ST_E, 4'h6);
    gotoState(3, ST_E, 4'h7);
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b0; cpuReqAddr = {4'h6, 2'd2};
    snpValid = 1'b1; snpWrite = 1'b1; snpAddr = {4'h7, 2'd3};
    #1;
    chk("R12", "cpuDone", int'(cpuDone), 1);
    chk("R12", "snpWbValid", int'(snpWbValid), 1);
    @(negedge clk); cpuReqValid = 1'b0; snpValid = 1'b0;
    mSt[3] = ST_I;
    cpuOp(1'b0, 4'h7, 3, 0, "R12");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule